// File: doc/BRIEF.md
# Framed Dual-Channel Serial DAC Loader

This block takes in-phase and quadrature sample words from a synchronous four-wire serial link. The wires are a clock, a framing line and one data line per channel. Both channels shift a 16-bit word in together, most significant bit first. The framing line is high for one clock just before the cycle that carries the two most significant bits. When the sixteenth bit arrives, the top ten bits of each word go into a pair of DAC holding registers. A one-cycle load strobe marks that update.

Words arrive back to back, so a holding register update happens every 16 clocks. Once the block has been framed, its bit counter runs freely. A framing pulse is expected only in the cycle that carries the last bit of a word. A framing pulse anywhere else drops the partial word, restarts the count and sets a sticky error flag. Until the first framing pulse after reset, the block loads nothing.

Top module: `iq_serial_dac_loader`

## Requirements
- R1: While reset is asserted (rstN low, asynchronous) and right after it is released, iDacOut and qDacOut are zero, and loadStrobe and frameErr are low.
- R2: Until frameIn has been sampled high after reset, loadStrobe stays low and both outputs stay zero, whatever the data lines carry.
- R3: All inputs are sampled on the rising clock edge. If frameIn is sampled high at edge k, the word bits are sampled at edges k+1 through k+16, MSB first.
- R4: After a load, iDacOut and qDacOut hold received word bits [15:6], which are the first ten bits received. The last six bits of a word have no effect on the outputs.
- R5: loadStrobe is high for exactly one cycle, starting just after the edge that samples bit 0 of a word. Both outputs change only in that cycle, and they change together.
- R6: Once framed, the block loads every 16 cycles even when no further frameIn pulse arrives. Two strobes are never less than 16 cycles apart.
- R7: A frameIn pulse sampled together with bit 0 of a word is the expected position. The word still loads, frameErr stays unchanged, and the next edge samples a new MSB.
- R8: A frameIn pulse at any other position after framing does three things. It drops the partial word without a strobe, it makes the next edge sample a new MSB, and it sets frameErr.
- R9: frameErr stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock; all sampling on the rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| frameIn | input | 1 | Framing pulse, high one clock before a word's MSB |
| iDataIn | input | 1 | In-phase serial data, MSB first |
| qDataIn | input | 1 | Quadrature serial data, MSB first |
| iDacOut | output | 10 | In-phase DAC holding register |
| qDacOut | output | 10 | Quadrature DAC holding register |
| loadStrobe | output | 1 | One-cycle pulse when both holding registers update |
| frameErr | output | 1 | Sticky flag: framing pulse seen at an unexpected position |

## Verification
In a back-to-back stream, the framing pulse for the next word falls in the same cycle as the last bit of the current word. That cycle both loads the finished word and restarts the count for the next one. The bench drives a stream of words with that overlap. For each word it checks that the finished word loads with the right top ten bits and that the error flag stays clear. It also checks that the following word's MSB is taken from the very next cycle. A framing pulse placed mid-word is judged separately: there must be no strobe, the flag must set, and the word that follows must realign.

// File: rtl/iq_dac_loader_pkg.sv
package iq_dac_loader_pkg;

  // Strobes from the framing control to the shift/hold datapath
  typedef struct packed {
    logic shiftEn;  // a word bit is present on the data lines this cycle
    logic loadEn;   // this cycle carries the final bit of a word
  } loaderCtrl_t;

endpackage

// File: rtl/iq_dac_loader_ctrl.sv
module iq_dac_loader_ctrl
  import iq_dac_loader_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        frameIn,
  output loaderCtrl_t ctrl,
  output logic        frameErr
);

  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

  logic             synced;
  logic [CNT_W-1:0] bitCnt;
  logic             atLast;

  assign atLast = (bitCnt == LAST_BIT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      synced   <= 1'b0;
      bitCnt   <= '0;
      frameErr <= 1'b0;
    end else if (frameIn) begin
      // Next edge carries an MSB, whatever the current position
      synced <= 1'b1;
      bitCnt <= '0;
      if (synced && !atLast) begin
        frameErr <= 1'b1;
      end
    end else if (synced) begin
      bitCnt <= atLast ? '0 : bitCnt + 1'b1;
    end
  end

  always_comb begin
    ctrl.shiftEn = synced;
    ctrl.loadEn  = synced && atLast;
  end

endmodule

// File: rtl/iq_dac_loader_dp.sv
module iq_dac_loader_dp
  import iq_dac_loader_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int DAC_W  = 10,
  parameter int NUM_CH = 2
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  loaderCtrl_t                  ctrl,
  input  logic [NUM_CH-1:0]            serialIn,
  output logic [NUM_CH-1:0][DAC_W-1:0] dacOut,
  output logic                         loadStrobe
);

  localparam int SHIFT_W = WORD_W - 1;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic [SHIFT_W-1:0] shiftReg;
    logic [DAC_W-1:0]   topBits;

    if (DAC_W < WORD_W) begin : g_trunc
      // The first DAC_W received bits already sit in the shift register
      assign topBits = shiftReg[SHIFT_W-1 -: DAC_W];
    end else begin : g_full
      assign topBits = {shiftReg, serialIn[ch]};
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        shiftReg <= '0;
      end else if (ctrl.shiftEn) begin
        shiftReg <= {shiftReg[SHIFT_W-2:0], serialIn[ch]};
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        dacOut[ch] <= '0;
      end else if (ctrl.loadEn) begin
        dacOut[ch] <= topBits;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loadStrobe <= 1'b0;
    end else begin
      loadStrobe <= ctrl.loadEn;
    end
  end

endmodule

// File: rtl/iq_serial_dac_loader.sv
module iq_serial_dac_loader
  import iq_dac_loader_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int DAC_W  = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameIn,
  input  logic             iDataIn,
  input  logic             qDataIn,
  output logic [DAC_W-1:0] iDacOut,
  output logic [DAC_W-1:0] qDacOut,
  output logic             loadStrobe,
  output logic             frameErr
);

  localparam int NUM_CH = 2;

  loaderCtrl_t                  ctrl;
  logic [NUM_CH-1:0][DAC_W-1:0] dacOut;

  iq_dac_loader_ctrl #(.WORD_W(WORD_W)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .frameIn  (frameIn),
    .ctrl     (ctrl),
    .frameErr (frameErr)
  );

  iq_dac_loader_dp #(.WORD_W(WORD_W), .DAC_W(DAC_W), .NUM_CH(NUM_CH)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .serialIn   ({qDataIn, iDataIn}),
    .dacOut     (dacOut),
    .loadStrobe (loadStrobe)
  );

  assign iDacOut = dacOut[0];
  assign qDacOut = dacOut[1];

endmodule

// File: rtl/iq_serial_dac_loader_chk.sv
module iq_serial_dac_loader_chk #(
  parameter int WORD_W = 16,
  parameter int DAC_W  = 10
) (
  input logic             clk,
  input logic             rstN,
  input logic             frameIn,
  input logic [DAC_W-1:0] iDacOut,
  input logic [DAC_W-1:0] qDacOut,
  input logic             loadStrobe,
  input logic             frameErr
);

  localparam int GAP_W = $clog2(WORD_W) + 1;
  localparam logic [GAP_W-1:0] GAP_MIN = GAP_W'(WORD_W - 1);
  localparam logic [GAP_W-1:0] GAP_SAT = GAP_W'(WORD_W);

  logic             seenFrame;
  logic             hadLoad;
  logic [GAP_W-1:0] gapCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seenFrame <= 1'b0;
      hadLoad   <= 1'b0;
      gapCnt    <= '0;
    end else begin
      if (frameIn) seenFrame <= 1'b1;
      if (loadStrobe) begin
        hadLoad <= 1'b1;
        gapCnt  <= '0;
      end else if (gapCnt != GAP_SAT) begin
        gapCnt <= gapCnt + 1'b1;
      end
    end
  end

  assert_quiet_unframed_R2: assert property (@(posedge clk) disable iff (!rstN)
    !seenFrame |-> (!loadStrobe && iDacOut == '0 && qDacOut == '0));

  assert_hold_between_loads_R5: assert property (@(posedge clk) disable iff (!rstN)
    !loadStrobe |-> ($stable(iDacOut) && $stable(qDacOut)));

  assert_strobe_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    loadStrobe |=> !loadStrobe);

  assert_load_spacing_R6: assert property (@(posedge clk) disable iff (!rstN)
    (loadStrobe && hadLoad) |-> (gapCnt >= GAP_MIN));

  assert_err_cause_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frameErr) |-> $past(frameIn));

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    frameErr |=> frameErr);

endmodule

bind iq_serial_dac_loader iq_serial_dac_loader_chk #(.WORD_W(WORD_W), .DAC_W(DAC_W)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .frameIn    (frameIn),
  .iDacOut    (iDacOut),
  .qDacOut    (qDacOut),
  .loadStrobe (loadStrobe),
  .frameErr   (frameErr)
);

// File: tb/iq_serial_dac_loader_tb_top.sv
module iq_serial_dac_loader_tb_top;

  localparam int WORD_W = 16;
  localparam int DAC_W  = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameIn = 1'b0;
  logic iDataIn = 1'b0;
  logic qDataIn = 1'b0;
  logic [DAC_W-1:0] iDacOut, qDacOut;
  logic loadStrobe, frameErr;

  int checkCnt = 0;
  int errCnt = 0;
  bit done = 1'b0;
  logic expErr = 1'b0;

  always #10 clk = ~clk;

  iq_serial_dac_loader #(.WORD_W(WORD_W), .DAC_W(DAC_W)) dut_i (
    .clk(clk), .rstN(rstN), .frameIn(frameIn), .iDataIn(iDataIn), .qDataIn(qDataIn),
    .iDacOut(iDacOut), .qDacOut(qDacOut), .loadStrobe(loadStrobe), .frameErr(frameErr)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (!ok) begin
      errCnt++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one cycle of inputs, then observe just after the sampling edge
  task automatic driveBit(input logic f, input logic i, input logic q);
    @(negedge clk);
    frameIn = f; iDataIn = i; qDataIn = q;
    @(posedge clk);
    #1;
  endtask

  task automatic applyReset();
    @(negedge clk);
    rstN = 1'b0; frameIn = 1'b0; iDataIn = 1'b0; qDataIn = 1'b0;
    #1;
    check(iDacOut == '0 && qDacOut == '0 && !loadStrobe && !frameErr, "R1 in reset",
          {iDacOut, qDacOut, loadStrobe, frameErr}, 0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    expErr = 1'b0;
    @(posedge clk); #1;
    check(iDacOut == '0 && qDacOut == '0 && !loadStrobe && !frameErr, "R1 after release",
          {iDacOut, qDacOut, loadStrobe, frameErr}, 0);
  endtask

  // Send one word on both lanes; lastFrame puts a framing pulse on its final bit
  task automatic sendWord(input logic [15:0] iw, input logic [15:0] qw, input logic lastFrame,
                          input string tag);
    logic [DAC_W-1:0] iHold = iDacOut;
    logic [DAC_W-1:0] qHold = qDacOut;
    bit quiet = 1'b1;
    for (int b = 0; b < WORD_W; b++) begin
      driveBit((b == WORD_W - 1) ? lastFrame : 1'b0, iw[WORD_W-1-b], qw[WORD_W-1-b]);
      if (b < WORD_W - 1 && (loadStrobe || iDacOut != iHold || qDacOut != qHold)) quiet = 1'b0;
    end
    check(quiet, {"R5 no update mid-word ", tag}, {iDacOut, qDacOut}, {iHold, qHold});
    check(loadStrobe == 1'b1, {"R5 strobe after bit 0 ", tag}, loadStrobe, 1);
    check(iDacOut == iw[15:6] && qDacOut == qw[15:6], {"R4 top ten bits ", tag},
          {iDacOut, qDacOut}, {iw[15:6], qw[15:6]});
    check(frameErr == expErr, {"R7 error flag ", tag}, frameErr, expErr);
  endtask

  task automatic testReset();
    applyReset();
  endtask

  task automatic testUnframed();
    bit quiet = 1'b1;
    for (int c = 0; c < 40; c++) begin
      driveBit(1'b0, c[0], ~c[1]);
      if (loadStrobe || iDacOut != '0 || qDacOut != '0) quiet = 1'b0;
    end
    check(quiet, "R2 no load before first frame", {loadStrobe, iDacOut, qDacOut}, 0);
  endtask

  task automatic testStream();
    driveBit(1'b1, 1'b1, 1'b1);  // first framing pulse
    check(!loadStrobe && !frameErr, "R3 first frame alone", {loadStrobe, frameErr}, 0);
    sendWord(16'hFFFF, 16'h0000, 1'b1, "R3 ones/zeros");
    sendWord(16'hA5C3, 16'h5A3C, 1'b1, "R7 back-to-back");
    sendWord(16'h8001, 16'h003F, 1'b1, "R4 low bits ignored");
    sendWord(16'h803E, 16'h0000, 1'b1, "R4 same top bits");
    sendWord(16'h1234, 16'hFEDC, 1'b0, "R6 no next frame");
    sendWord(16'h4C07, 16'hB3F8, 1'b0, "R6 free-running");
    sendWord(16'h0FC0, 16'hF03F, 1'b1, "R6 resume framing");
  endtask

  task automatic testMisplaced();
    logic [DAC_W-1:0] iPrev = iDacOut;
    logic [DAC_W-1:0] qPrev = qDacOut;
    for (int c = 0; c < 5; c++) driveBit(1'b0, 1'b1, 1'b0);
    driveBit(1'b1, 1'b0, 1'b1);   // framing pulse at bit position 10
    expErr = 1'b1;
    check(frameErr == 1'b1, "R8 misplaced frame sets error", frameErr, 1);
    check(!loadStrobe && iDacOut == iPrev && qDacOut == qPrev, "R8 partial word dropped",
          {loadStrobe, iDacOut, qDacOut}, {1'b0, iPrev, qPrev});
    sendWord(16'hC3A5, 16'h3C5A, 1'b1, "R8 realigned word");
    sendWord(16'h7E81, 16'h817E, 1'b0, "R9 error held");
    check(frameErr == 1'b1, "R9 sticky error", frameErr, 1);
  endtask

  task automatic testResetMidStream();
    for (int c = 0; c < 7; c++) driveBit(1'b0, 1'b1, 1'b1);
    applyReset();
    testUnframed();
  endtask

  initial begin
    testReset();
    testUnframed();
    testStream();
    testMisplaced();
    testResetMidStream();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checkCnt, errCnt);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checkCnt++;
      errCnt++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checkCnt, errCnt);
      $finish;
    end
  end

endmodule